// File: doc/BRIEF.md
# Single-Cycle Ten-Instruction Processor Core

This block is a small 32-bit processor core that retires one instruction on every clock edge. It holds a program counter and a bank of 32 general registers. On each cycle it presents the program counter on an instruction fetch port and takes back one 32-bit word. It decodes that word and reads two source registers. An arithmetic and logic unit produces a result or a memory address, and any load or store goes through a data port. The result is written back and the next program counter is chosen, all within the same cycle. Both memories sit outside the block and must answer reads combinationally within the cycle.

The instruction set is limited to five register-to-register operations (wrapping add, wrapping subtract, AND, OR, NOR), one add-immediate, a word load, a word store, an equality branch and an absolute jump. One extra encoding, the all-ones word, stops the core. Once that word is fetched the program counter, the registers and the data memory are never changed again until reset, and a status output stays high. Every other encoding executes as a no-op.

Top module: `sc_core`

## Requirements
- R1: On reset the program counter is zero, `halted` is low, and in the default configuration every register reads zero.
- R2: With primary opcode 0x00 (bits 31:26), the function field in bits 5:0 selects the operation: 0x21 adds, 0x23 subtracts (rs minus rt), 0x24 ANDs, 0x25 ORs and 0x27 NORs the registers named by bits 25:21 (rs) and 20:16 (rt). The result goes to the register named by bits 15:11 (rd), and add and subtract wrap modulo 2^32.
- R3: Opcode 0x09 adds rs to the sign-extended 16-bit immediate in bits 15:0. The sum wraps modulo 2^32 and is written to rt.
- R4: Register 0 always reads zero, and a write aimed at it has no effect.
- R5: Opcode 0x23 drives `dmem_addr` with rs plus the sign-extended immediate, raises `dmem_re`, and writes `dmem_rdata` to rt.
- R6: Opcode 0x2B drives `dmem_addr` with rs plus the sign-extended immediate and `dmem_wdata` with rt, and raises `dmem_we` for that one cycle. `dmem_we` is low for every other instruction.
- R7: Opcode 0x04 compares rs and rt. When they are equal the next program counter is PC+4 plus the sign-extended immediate shifted left by two. Otherwise it is PC+4.
- R8: Opcode 0x02 sets the program counter to the upper four bits of PC+4, followed by the 26-bit index in bits 25:0, followed by two zero bits.
- R9: Every instruction other than a branch, a jump or halt advances the program counter by 4.
- R10: An unrecognised opcode, an unrecognised function code, or an opcode-0x3F word that is not all ones writes nothing and advances the program counter by 4.
- R11: The word 0xFFFFFFFF raises `halted` in the cycle it is decoded. From then until reset, the program counter, the registers and the data memory stay unchanged, and `halted` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_addr | output | 32 | Current program counter, byte address of the fetched word |
| imem_data | input | 32 | Instruction word at `imem_addr` |
| dmem_addr | output | 32 | Byte address for a load or store |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store strobe, one per store instruction |
| dmem_re | output | 1 | Load strobe |
| dmem_rdata | input | 32 | Load data returned for `dmem_addr` |
| halted | output | 1 | High from the cycle halt is decoded until reset |

## Verification
The registers cannot be seen at the ports, so every register result is brought out through a later store and checked on `dmem_wdata`. This covers results written to register 0, results that wrap, and results of encodings that must be ignored. The hardest case is the frozen state after halt. The bench therefore keeps feeding real stores, adds and jumps after the halt word and checks that no strobe appears and that the fetch address does not move. It then resets and runs a store of a register to show that the state was cleared.

// File: rtl/sc_core_pkg.sv
package sc_core_pkg;

   localparam logic [5:0] OPC_RTYPE = 6'h00;
   localparam logic [5:0] OPC_JUMP  = 6'h02;
   localparam logic [5:0] OPC_BEQ   = 6'h04;
   localparam logic [5:0] OPC_ADDI  = 6'h09;
   localparam logic [5:0] OPC_LOAD  = 6'h23;
   localparam logic [5:0] OPC_STORE = 6'h2B;

   localparam logic [5:0] FN_ADD = 6'h21;
   localparam logic [5:0] FN_SUB = 6'h23;
   localparam logic [5:0] FN_AND = 6'h24;
   localparam logic [5:0] FN_OR  = 6'h25;
   localparam logic [5:0] FN_NOR = 6'h27;

   typedef enum logic [2:0] {
      ALU_ADD,
      ALU_SUB,
      ALU_AND,
      ALU_OR,
      ALU_NOR
   } alu_op_e;

   typedef struct packed {
      logic    reg_we;
      logic    dst_rt;
      logic    alu_imm;
      logic    mem_rd;
      logic    mem_wr;
      logic    is_beq;
      logic    is_jump;
      logic    is_halt;
      alu_op_e alu_op;
   } ctrl_t;

endpackage

// File: rtl/sc_core_decode.sv
module sc_core_decode
   import sc_core_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic [XLEN-1:0] instr,
   output ctrl_t           ctrl
);

   localparam logic [XLEN-1:0] HALT_WORD = {XLEN{1'b1}};

   logic [5:0] opc;
   logic [5:0] fn;

   assign opc = instr[31:26];
   assign fn  = instr[5:0];

   always_comb begin
      ctrl        = '0;
      ctrl.alu_op = ALU_ADD;
      if (instr == HALT_WORD) begin
         ctrl.is_halt = 1'b1;
      end else begin
         case (opc)
            OPC_RTYPE: begin
               ctrl.reg_we = 1'b1;
               case (fn)
                  FN_ADD:  ctrl.alu_op = ALU_ADD;
                  FN_SUB:  ctrl.alu_op = ALU_SUB;
                  FN_AND:  ctrl.alu_op = ALU_AND;
                  FN_OR:   ctrl.alu_op = ALU_OR;
                  FN_NOR:  ctrl.alu_op = ALU_NOR;
                  default: ctrl.reg_we = 1'b0;
               endcase
            end
            OPC_ADDI: begin
               ctrl.reg_we  = 1'b1;
               ctrl.dst_rt  = 1'b1;
               ctrl.alu_imm = 1'b1;
            end
            OPC_LOAD: begin
               ctrl.reg_we  = 1'b1;
               ctrl.dst_rt  = 1'b1;
               ctrl.alu_imm = 1'b1;
               ctrl.mem_rd  = 1'b1;
            end
            OPC_STORE: begin
               ctrl.alu_imm = 1'b1;
               ctrl.mem_wr  = 1'b1;
            end
            OPC_BEQ:  ctrl.is_beq  = 1'b1;
            OPC_JUMP: ctrl.is_jump = 1'b1;
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/sc_core_alu.sv
module sc_core_alu
   import sc_core_pkg::*;
#(
   parameter int W = 32
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  alu_op_e      op,
   output logic [W-1:0] y
);

   always_comb begin
      case (op)
         ALU_ADD: y = a + b;
         ALU_SUB: y = a - b;
         ALU_AND: y = a & b;
         ALU_OR:  y = a | b;
         ALU_NOR: y = ~(a | b);
         default: y = '0;
      endcase
   end

endmodule

// File: rtl/sc_core_regfile.sv
module sc_core_regfile #(
   parameter int W              = 32,
   parameter int NREGS          = 32,
   parameter bit CLEAR_ON_RESET = 1'b1,
   localparam int AW            = $clog2(NREGS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] ra_a,
   input  logic [AW-1:0] ra_b,
   output logic [W-1:0]  rdata_a,
   output logic [W-1:0]  rdata_b,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [W-1:0]  wdata
);

   if (NREGS < 2 || (1 << AW) != NREGS) begin : g_bad_depth
      $error("sc_core_regfile: NREGS must be a power of two of at least 2");
   end

   logic [W-1:0] bank [NREGS];

   for (genvar i = 0; i < NREGS; i++) begin : g_reg
      if (i == 0) begin : g_zero
         assign bank[i] = '0;
      end else if (CLEAR_ON_RESET) begin : g_clr
         logic [W-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               q <= '0;
            end else if (we && waddr == AW'(i)) begin
               q <= wdata;
            end
         end
         assign bank[i] = q;
      end else begin : g_keep
         logic [W-1:0] q;
         always_ff @(posedge clk) begin
            if (we && waddr == AW'(i)) begin
               q <= wdata;
            end
         end
         assign bank[i] = q;
      end
   end

   assign rdata_a = bank[ra_a];
   assign rdata_b = bank[ra_b];

   // R4
   zero_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ra_b == '0) |-> (rdata_b == '0));

endmodule

// File: rtl/sc_core_pc.sv
module sc_core_pc #(
   parameter int              XLEN     = 32,
   parameter int              JIDX_W   = 26,
   parameter logic [XLEN-1:0] RESET_PC = '0,
   localparam int             TOPW     = XLEN - JIDX_W - 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              advance,
   input  logic              take_branch,
   input  logic              take_jump,
   input  logic [XLEN-1:0]   br_offset,
   input  logic [JIDX_W-1:0] jump_index,
   output logic [XLEN-1:0]   pc_q
);

   if (TOPW < 1) begin : g_bad_jw
      $error("sc_core_pc: jump index too wide for XLEN");
   end

   logic [XLEN-1:0] pc_plus4;
   logic [XLEN-1:0] br_target;
   logic [XLEN-1:0] j_target;
   logic [XLEN-1:0] pc_next;

   assign pc_plus4  = pc_q + XLEN'(4);
   assign br_target = pc_plus4 + (br_offset << 2);
   assign j_target  = {pc_plus4[XLEN-1 -: TOPW], jump_index, 2'b00};

   always_comb begin
      if (take_jump) begin
         pc_next = j_target;
      end else if (take_branch) begin
         pc_next = br_target;
      end else begin
         pc_next = pc_plus4;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q <= RESET_PC;
      end else if (advance) begin
         pc_q <= pc_next;
      end
   end

   // R8
   pc_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pc_q[1:0] == 2'b00);

endmodule

// File: rtl/sc_core.sv
module sc_core
   import sc_core_pkg::*;
#(
   parameter int  XLEN       = 32,
   parameter int  NUM_REGS   = 32,
   parameter bit  CLEAR_REGS = 1'b1,
   localparam int RAW        = $clog2(NUM_REGS),
   localparam int IMM_W      = 16,
   localparam int JIDX_W     = 26
) (
   input  logic            clk,
   input  logic            rst_n,
   output logic [XLEN-1:0] imem_addr,
   input  logic [XLEN-1:0] imem_data,
   output logic [XLEN-1:0] dmem_addr,
   output logic [XLEN-1:0] dmem_wdata,
   output logic            dmem_we,
   output logic            dmem_re,
   input  logic [XLEN-1:0] dmem_rdata,
   output logic            halted
);

   if (XLEN != 32) begin : g_bad_xlen
      $error("sc_core: the instruction encoding fixes XLEN at 32");
   end
   if (NUM_REGS != 32) begin : g_bad_regs
      $error("sc_core: five-bit register fields need NUM_REGS of 32");
   end

   ctrl_t           ctrl;
   logic            halted_q;
   logic            run;
   logic [RAW-1:0]  rs_idx;
   logic [RAW-1:0]  rt_idx;
   logic [RAW-1:0]  rd_idx;
   logic [RAW-1:0]  wr_idx;
   logic [XLEN-1:0] rs_val;
   logic [XLEN-1:0] rt_val;
   logic [XLEN-1:0] imm_sx;
   logic [XLEN-1:0] alu_b;
   logic [XLEN-1:0] alu_y;
   logic [XLEN-1:0] wb_val;
   logic            rf_we;
   logic            br_taken;

   sc_core_decode #(.XLEN(XLEN)) u_dec (
      .instr (imem_data),
      .ctrl  (ctrl)
   );

   assign rs_idx = imem_data[25:21];
   assign rt_idx = imem_data[20:16];
   assign rd_idx = imem_data[15:11];
   assign imm_sx = {{(XLEN-IMM_W){imem_data[IMM_W-1]}}, imem_data[IMM_W-1:0]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         halted_q <= 1'b0;
      end else if (ctrl.is_halt) begin
         halted_q <= 1'b1;
      end
   end

   assign run    = !halted_q && !ctrl.is_halt;
   assign halted = halted_q || ctrl.is_halt;

   sc_core_regfile #(
      .W              (XLEN),
      .NREGS          (NUM_REGS),
      .CLEAR_ON_RESET (CLEAR_REGS)
   ) u_rf (
      .clk     (clk),
      .rst_n   (rst_n),
      .ra_a    (rs_idx),
      .ra_b    (rt_idx),
      .rdata_a (rs_val),
      .rdata_b (rt_val),
      .we      (rf_we),
      .waddr   (wr_idx),
      .wdata   (wb_val)
   );

   assign alu_b = ctrl.alu_imm ? imm_sx : rt_val;

   sc_core_alu #(.W(XLEN)) u_alu (
      .a  (rs_val),
      .b  (alu_b),
      .op (ctrl.alu_op),
      .y  (alu_y)
   );

   assign dmem_addr  = alu_y;
   assign dmem_wdata = rt_val;
   assign dmem_we    = ctrl.mem_wr && run;
   assign dmem_re    = ctrl.mem_rd && run;

   assign wb_val = ctrl.mem_rd ? dmem_rdata : alu_y;
   assign wr_idx = ctrl.dst_rt ? rt_idx : rd_idx;
   assign rf_we  = ctrl.reg_we && run;

   assign br_taken = ctrl.is_beq && (rs_val == rt_val);

   sc_core_pc #(
      .XLEN   (XLEN),
      .JIDX_W (JIDX_W)
   ) u_pc (
      .clk         (clk),
      .rst_n       (rst_n),
      .advance     (run),
      .take_branch (br_taken),
      .take_jump   (ctrl.is_jump),
      .br_offset   (imm_sx),
      .jump_index  (imem_data[JIDX_W-1:0]),
      .pc_q        (imem_addr)
   );

   // R11
   halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> halted);

   // R11
   pc_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> $stable(imem_addr));

   // R6
   no_mem_when_halted_chk: assert property (@(posedge clk) disable iff (!rst_n)
      halted |-> (!dmem_we && !dmem_re));

   // R9
   pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!halted && !ctrl.is_beq && !ctrl.is_jump) |=> (imem_addr == $past(imem_addr) + XLEN'(4)));

endmodule

// File: tb/sc_core_test.sv
`timescale 1ns/1ps
module sc_core_test;

   typedef struct packed {
      logic [31:0] instr;
      logic [31:0] rdata;
      logic [31:0] pc;
      logic [1:0]  kind;   // 0 none, 1 store, 2 load
      logic [31:0] addr;
      logic [31:0] wdata;
      logic [3:0]  pc_req;
      logic [3:0]  mem_req;
   } vec_t;

   localparam int NV = 26;

   // pc_req / mem_req hold the requirement number: R1 R2 R3 R4 R5 R6 R7 R8 R9 R10
   localparam vec_t [0:NV-1] VEC = '{
      '{32'h24010005, 32'h0, 32'd0,   2'd0, 32'h0,  32'h0,        4'd1,  4'd3},  // r1=5
      '{32'h2402FFFD, 32'h0, 32'd4,   2'd0, 32'h0,  32'h0,        4'd9,  4'd3},  // r2=-3
      '{32'h00221821, 32'h0, 32'd8,   2'd0, 32'h0,  32'h0,        4'd9,  4'd2},  // r3=r1+r2
      '{32'hAC030008, 32'h0, 32'd12,  2'd1, 32'd8,  32'd2,        4'd9,  4'd2},  // sw r3
      '{32'h00222023, 32'h0, 32'd16,  2'd0, 32'h0,  32'h0,        4'd9,  4'd2},  // r4=r1-r2
      '{32'hAC24FFFC, 32'h0, 32'd20,  2'd1, 32'd1,  32'd8,        4'd9,  4'd6},  // sw r4,-4(r1)
      '{32'h00222824, 32'h0, 32'd24,  2'd0, 32'h0,  32'h0,        4'd9,  4'd2},  // and
      '{32'h00223025, 32'h0, 32'd28,  2'd0, 32'h0,  32'h0,        4'd9,  4'd2},  // or
      '{32'h00223827, 32'h0, 32'd32,  2'd0, 32'h0,  32'h0,        4'd9,  4'd2},  // nor
      '{32'hAC050000, 32'h0, 32'd36,  2'd1, 32'd0,  32'd5,        4'd9,  4'd2},
      '{32'hAC060004, 32'h0, 32'd40,  2'd1, 32'd4,  32'hFFFFFFFD, 4'd9,  4'd2},
      '{32'hAC07000C, 32'h0, 32'd44,  2'd1, 32'd12, 32'd2,        4'd9,  4'd2},
      '{32'h8C280010, 32'h12345678, 32'd48, 2'd2, 32'd21, 32'h0,  4'd9,  4'd5},  // lw r8
      '{32'hAC080000, 32'h0, 32'd52,  2'd1, 32'd0,  32'h12345678, 4'd9,  4'd5},
      '{32'h24000007, 32'h0, 32'd56,  2'd0, 32'h0,  32'h0,        4'd9,  4'd4},  // write r0
      '{32'hAC000000, 32'h0, 32'd60,  2'd1, 32'd0,  32'd0,        4'd9,  4'd4},
      '{32'h00214821, 32'h0, 32'd64,  2'd0, 32'h0,  32'h0,        4'd9,  4'd2},  // r9=10
      '{32'h10290005, 32'h0, 32'd68,  2'd0, 32'h0,  32'h0,        4'd9,  4'd7},  // beq not taken
      '{32'h10210003, 32'h0, 32'd72,  2'd0, 32'h0,  32'h0,        4'd7,  4'd7},  // beq fwd
      '{32'h1021FFFE, 32'h0, 32'd88,  2'd0, 32'h0,  32'h0,        4'd7,  4'd7},  // beq back
      '{32'h08000040, 32'h0, 32'd84,  2'd0, 32'h0,  32'h0,        4'd7,  4'd8},  // j
      '{32'hFC000000, 32'h0, 32'd256, 2'd0, 32'h0,  32'h0,        4'd8,  4'd10}, // bad opc
      '{32'h00420820, 32'h0, 32'd260, 2'd0, 32'h0,  32'h0,        4'd10, 4'd10}, // bad funct
      '{32'hAC010000, 32'h0, 32'd264, 2'd1, 32'd0,  32'd5,        4'd10, 4'd10},
      '{32'h24CA0005, 32'h0, 32'd268, 2'd0, 32'h0,  32'h0,        4'd9,  4'd3},  // wrap
      '{32'hAC0A0000, 32'h0, 32'd272, 2'd1, 32'd0,  32'd2,        4'd9,  4'd3}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] imem_addr;
   logic [31:0] imem_data = 32'h0;
   logic [31:0] dmem_addr;
   logic [31:0] dmem_wdata;
   logic        dmem_we;
   logic        dmem_re;
   logic [31:0] dmem_rdata = 32'h0;
   logic        halted;

   int total = 0;
   int bad = 0;

   always #5 clk = ~clk;

   sc_core uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .imem_addr  (imem_addr),
      .imem_data  (imem_data),
      .dmem_addr  (dmem_addr),
      .dmem_wdata (dmem_wdata),
      .dmem_we    (dmem_we),
      .dmem_re    (dmem_re),
      .dmem_rdata (dmem_rdata),
      .halted     (halted)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // drive at a falling edge, let it settle; the caller checks, then advance
   task automatic drive(input logic [31:0] ins, input logic [31:0] rd);
      imem_data  = ins;
      dmem_rdata = rd;
      #1;
   endtask

   task automatic next_edge();
      @(negedge clk);
   endtask

   task automatic finish_run();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      #2_000_000;
      total++;
      bad++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
      finish_run();
   end

   initial begin
      next_edge();
      drive(32'h0, 32'h0);
      chk("R1 reset pc", imem_addr, 32'h0);
      chk("R1 reset halted", {31'h0, halted}, 32'h0);
      next_edge();
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         drive(VEC[i].instr, VEC[i].rdata);
         chk($sformatf("R%0d vec %0d pc", VEC[i].pc_req, i), imem_addr, VEC[i].pc);
         chk($sformatf("R%0d vec %0d we", VEC[i].mem_req, i), {31'h0, dmem_we},
             {31'h0, VEC[i].kind == 2'd1});
         chk($sformatf("R%0d vec %0d re", VEC[i].mem_req, i), {31'h0, dmem_re},
             {31'h0, VEC[i].kind == 2'd2});
         if (VEC[i].kind != 2'd0) begin
            chk($sformatf("R%0d vec %0d addr", VEC[i].mem_req, i), dmem_addr, VEC[i].addr);
         end
         if (VEC[i].kind == 2'd1) begin
            chk($sformatf("R%0d vec %0d wdata", VEC[i].mem_req, i), dmem_wdata, VEC[i].wdata);
         end
         next_edge();
      end

      // R11: halt word raises halted in its own cycle
      drive(32'hFFFFFFFF, 32'h0);
      chk("R11 halt pc", imem_addr, 32'd276);
      chk("R11 halted same cycle", {31'h0, halted}, 32'h1);
      chk("R11 halt no store", {31'h0, dmem_we}, 32'h0);
      next_edge();

      // R11: store, add and jump after halt change nothing
      drive(32'hAC010000, 32'h0);
      chk("R11 frozen store strobe", {31'h0, dmem_we}, 32'h0);
      chk("R11 halted stays", {31'h0, halted}, 32'h1);
      next_edge();
      drive(32'h24010063, 32'h0);
      next_edge();
      drive(32'h08000000, 32'h0);
      chk("R11 pc frozen", imem_addr, 32'd276);
      next_edge();
      drive(32'h8C010000, 32'h0);
      chk("R11 frozen load strobe", {31'h0, dmem_re}, 32'h0);
      chk("R11 pc still frozen", imem_addr, 32'd276);

      // R1: reset clears pc, halted and registers
      rst_n = 1'b0;
      #1;
      chk("R1 reset pc after halt", imem_addr, 32'h0);
      drive(32'h0, 32'h0);
      chk("R1 reset clears halted", {31'h0, halted}, 32'h0);
      next_edge();
      rst_n = 1'b1;
      drive(32'hAC010000, 32'h0);
      chk("R1 register cleared", dmem_wdata, 32'h0);
      chk("R1 store after reset", {31'h0, dmem_we}, 32'h1);
      next_edge();

      // R10: opcode 0x3F word that is not all ones is a no-op
      drive(32'hFC000001, 32'h0);
      chk("R10 near-halt pc", imem_addr, 32'd4);
      chk("R10 near-halt not halted", {31'h0, halted}, 32'h0);
      next_edge();
      drive(32'h0, 32'h0);
      chk("R10 near-halt advances", imem_addr, 32'd8);
      chk("R10 still running", {31'h0, halted}, 32'h0);

      finish_run();
   end

endmodule